// File: doc/BRIEF.md
# Two-Phase Toggle Handshake Bridge

This block moves one data word at a time from a source clock domain to a destination clock domain when the two clocks have no known phase or frequency relationship. A transfer is signalled by a transition on a single request line, not by a level. The destination answers with a transition on a single acknowledge line. Each line passes through a synchronizer chain in the domain that receives it. The word itself crosses without a synchronizer. This is safe because the source holds it unchanged in a register for the whole time a transfer is in flight.

On the source side the user drives a one-cycle send strobe together with the word and watches a busy flag. A strobe given while busy is dropped. On the destination side the user gets the word on a registered data output together with a valid pulse one destination cycle long. No transfer ever needs the lines to return to a rest level. The link is idle whenever request and synchronized acknowledge agree, whether both are low or both are high.

Top module: `toggle_xfer_bridge`

## Requirements
- R1: While either reset is held and in the first cycle after it, `s_busy` is 0, `d_valid` is 0 and `d_data` is all zeros.
- R2: A `s_send` high at a source clock edge while `s_busy` is 0 is accepted. `s_busy` reads 1 after that same edge.
- R3: A `s_send` high while `s_busy` is 1 is dropped: it produces no delivery and does not extend the busy period.
- R4: The word delivered for a transfer is the value of `s_data` at the accepting edge. Later changes of `s_data` while busy do not alter it.
- R5: Each accepted transfer produces exactly one `d_valid` pulse, one destination cycle wide.
- R6: `d_data` changes only together with a `d_valid` pulse and otherwise holds the last delivered word.
- R7: `d_valid` rises after the third destination clock edge that follows the source edge which accepted the transfer.
- R8: `s_busy` falls after the second source clock edge that follows the destination edge which raised `d_valid`.
- R9: Transfers work alike from either line polarity. After one transfer leaves both lines high, the next accepted transfer behaves as from the low state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| s_clk | input | 1 | Source domain clock |
| s_rst | input | 1 | Source domain synchronous reset, active high |
| s_send | input | 1 | Request to transfer `s_data`, taken when not busy |
| s_data | input | DATA_W | Word to transfer |
| s_busy | output | 1 | A transfer is in flight; new sends are dropped |
| d_clk | input | 1 | Destination domain clock |
| d_rst | input | 1 | Destination domain synchronous reset, active high |
| d_data | output | DATA_W | Last delivered word |
| d_valid | output | 1 | One-cycle pulse marking a new word on `d_data` |

## Verification
A stuck or wrong toggle state appears at the ports within one round trip. Either `s_busy` never clears, or it clears without a matching `d_valid` pulse. With the clocks used, that takes about five destination cycles plus three source cycles after a send. A source data register that is not held shows up as the wrong word on `d_data` at the next pulse. An edge detector that compares the wrong stages shows `d_valid` one cycle early or late, or two cycles wide. The bench compares `s_busy`, `d_valid` and `d_data` against a per-edge model in every cycle of each domain, so any of these appears on the first cycle it occurs.

// File: rtl/hs_pkg.sv
package hs_pkg;
  // fewest flops allowed in any synchronizer chain of the bridge
  localparam int unsigned MIN_SYNC_STAGES = 2;
  localparam int unsigned DEF_DATA_W      = 16;
endpackage

// File: rtl/hs_sync_chain.sv
module hs_sync_chain #(
  parameter int unsigned STAGES = hs_pkg::MIN_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= 1'b0;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];

  initial begin
    assert (STAGES >= hs_pkg::MIN_SYNC_STAGES)
      else $error("synchronizer chain too short");
  end
endmodule

// File: rtl/hs_src_side.sv
module hs_src_side #(
  parameter int unsigned DATA_W      = hs_pkg::DEF_DATA_W,
  parameter int unsigned SYNC_STAGES = hs_pkg::MIN_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              send,
  input  logic [DATA_W-1:0] data_in,
  input  logic              ack_async,
  output logic              req_out,
  output logic [DATA_W-1:0] data_out,
  output logic              busy
);
  logic              req_q;
  logic [DATA_W-1:0] hold_q;
  logic              ack_seen;
  logic              take;

  hs_sync_chain #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (ack_async),
    .dout (ack_seen)
  );

  // lines disagree -> a transfer is still travelling
  assign busy = req_q ^ ack_seen;
  assign take = send & ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      hold_q <= '0;
    end else if (take) begin
      req_q  <= ~req_q;
      hold_q <= data_in;
    end
  end

  assign req_out  = req_q;
  assign data_out = hold_q;

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(hold_q)); // R4

  AST_REQ_ONLY_ON_TAKE: assert property (@(posedge clk) disable iff (rst)
    !(send && !busy) |=> $stable(req_q)); // R3

  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
    (send && !busy) |=> busy); // R2
endmodule

// File: rtl/hs_dst_side.sv
module hs_dst_side #(
  parameter int unsigned DATA_W      = hs_pkg::DEF_DATA_W,
  parameter int unsigned SYNC_STAGES = hs_pkg::MIN_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_async,
  input  logic [DATA_W-1:0] data_async,
  output logic              ack_out,
  output logic [DATA_W-1:0] data_out,
  output logic              valid
);
  logic              req_seen;
  logic              req_last_q;
  logic              ack_q;
  logic              valid_q;
  logic [DATA_W-1:0] word_q;
  logic              edge_hit;

  hs_sync_chain #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (req_async),
    .dout (req_seen)
  );

  // extra delayed copy for transition detection
  always_ff @(posedge clk) begin
    if (rst) req_last_q <= 1'b0;
    else     req_last_q <= req_seen;
  end

  assign edge_hit = req_seen ^ req_last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q   <= 1'b0;
      valid_q <= 1'b0;
      word_q  <= '0;
    end else begin
      valid_q <= edge_hit;
      if (edge_hit) begin
        ack_q  <= ~ack_q;
        word_q <= data_async;
      end
    end
  end

  assign ack_out  = ack_q;
  assign data_out = word_q;
  assign valid    = valid_q;

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q); // R5

  AST_ACK_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> (ack_q != $past(ack_q))); // R5

  AST_WORD_STABLE: assert property (@(posedge clk) disable iff (rst)
    !valid_q |-> $stable(word_q)); // R6
endmodule

// File: rtl/toggle_xfer_bridge.sv
module toggle_xfer_bridge #(
  parameter int unsigned DATA_W      = hs_pkg::DEF_DATA_W,
  parameter int unsigned SYNC_STAGES = hs_pkg::MIN_SYNC_STAGES
) (
  input  logic              s_clk,
  input  logic              s_rst,
  input  logic              s_send,
  input  logic [DATA_W-1:0] s_data,
  output logic              s_busy,
  input  logic              d_clk,
  input  logic              d_rst,
  output logic [DATA_W-1:0] d_data,
  output logic              d_valid
);
  logic              req_line;
  logic              ack_line;
  logic [DATA_W-1:0] held_word;

  hs_src_side #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk       (s_clk),
    .rst       (s_rst),
    .send      (s_send),
    .data_in   (s_data),
    .ack_async (ack_line),
    .req_out   (req_line),
    .data_out  (held_word),
    .busy      (s_busy)
  );

  hs_dst_side #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dst (
    .clk        (d_clk),
    .rst        (d_rst),
    .req_async  (req_line),
    .data_async (held_word),
    .ack_out    (ack_line),
    .data_out   (d_data),
    .valid      (d_valid)
  );

  AST_RESET_QUIET: assert property (@(posedge d_clk)
    d_rst |=> (!d_valid && d_data == '0)); // R1
endmodule

// File: tb/sim_toggle_xfer_bridge.sv
`timescale 1ns/1ps
module sim_toggle_xfer_bridge;
  localparam int W = 16;

  logic         s_clk = 1'b0, d_clk = 1'b0;
  logic         s_rst = 1'b1, d_rst = 1'b1;
  logic         s_send = 1'b0;
  logic [W-1:0] s_data = '0;
  logic         s_busy, d_valid;
  logic [W-1:0] d_data;

  int n_cmp = 0, n_bad = 0;
  int n_taken = 0, n_got = 0;
  logic [W-1:0] last_got = '0;
  logic [W-1:0] pend[$];

  always #10 s_clk = ~s_clk;           // 50 MHz
  initial begin #3; forever #7 d_clk = ~d_clk; end

  toggle_xfer_bridge #(.DATA_W(W)) u0 (
    .s_clk(s_clk), .s_rst(s_rst), .s_send(s_send), .s_data(s_data), .s_busy(s_busy),
    .d_clk(d_clk), .d_rst(d_rst), .d_data(d_data), .d_valid(d_valid)
  );

  // behavioural reference: line values and per-domain sample delays
  bit m_req, m_ack, m_a1, m_a2, m_r1, m_r2, m_r3, m_valid;
  logic [W-1:0] m_word, m_out;

  always @(posedge s_clk) begin
    if (s_rst) begin
      m_req <= 0; m_a1 <= 0; m_a2 <= 0; m_word <= '0;
    end else begin
      m_a1 <= m_ack; m_a2 <= m_a1;
      if (s_send && (m_req == m_a2)) begin
        m_req <= !m_req; m_word <= s_data;
        pend.push_back(s_data); n_taken++;
      end
    end
  end

  always @(posedge d_clk) begin
    if (d_rst) begin
      m_r1 <= 0; m_r2 <= 0; m_r3 <= 0; m_ack <= 0; m_valid <= 0; m_out <= '0;
    end else begin
      m_r1 <= m_req; m_r2 <= m_r1; m_r3 <= m_r2;
      m_valid <= (m_r2 != m_r3);
      if (m_r2 != m_r3) begin m_ack <= !m_ack; m_out <= m_word; end
    end
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edges
  always @(negedge s_clk) chk("R2/R3/R8 busy", {15'd0, s_busy}, {15'd0, (m_req != m_a2)});
  always @(negedge d_clk) begin
    chk("R5/R7 valid", {15'd0, d_valid}, {15'd0, m_valid});
    chk("R6 data", d_data, m_out);
    if (!d_rst && d_valid) begin
      n_got++; last_got = d_data;
      if (pend.size() == 0) chk("R5 unexpected pulse", 16'd1, 16'd0);
      else chk("R4 delivered word", d_data, pend.pop_front());
    end
  end

  task automatic s_cyc(input int n);
    repeat (n) @(negedge s_clk);
  endtask

  task automatic send_word(input logic [W-1:0] w);
    s_data = w; s_send = 1'b1; s_cyc(1); s_send = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (s_busy && guard < 200) begin s_cyc(1); guard++; end
    s_cyc(4);
  endtask

  initial begin
    #205;
    chk("R1 busy in reset", {15'd0, s_busy}, 16'd0);
    chk("R1 valid in reset", {15'd0, d_valid}, 16'd0);
    chk("R1 data in reset", d_data, 16'd0);
    s_rst = 1'b0; d_rst = 1'b0;
    s_cyc(3);
    chk("R1 busy after reset", {15'd0, s_busy}, 16'd0);

    send_word(16'h1111);
    chk("R2 busy after accept", {15'd0, s_busy}, 16'd1);
    wait_idle();
    chk("R5 one delivery", n_got[W-1:0], 16'd1);

    // lines now both high: second transfer from the other polarity
    send_word(16'h2222);
    chk("R9 busy from high state", {15'd0, s_busy}, 16'd1);
    s_data = 16'hDEAD; s_cyc(1);
    send_word(16'h3333);                // dropped: still busy
    s_data = 16'hBEEF; s_cyc(1);
    wait_idle();
    chk("R3 dropped send", n_got[W-1:0], 16'd2);
    chk("R4 held word", last_got, 16'h2222);
    chk("R9 idle after second", {15'd0, s_busy}, 16'd0);

    // continuous strobe with changing data
    s_send = 1'b1;
    for (int i = 0; i < 60; i++) begin s_data = 16'h4000 + i[W-1:0]; s_cyc(1); end
    s_send = 1'b0;
    wait_idle();
    s_cyc(10);
    chk("R5 deliveries match accepts", n_got[W-1:0], n_taken[W-1:0]);
    chk("R3 nothing pending", pend.size(), 0);

    send_word(16'h5A5A);
    wait_idle();
    chk("R6 final word", d_data, 16'h5A5A);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule